// File: doc/BRIEF.md
# Polyphase Decimate-by-48 Complex FIR

This block low-pass filters a complex baseband stream and lowers its sample rate by 48 in one stage. Each accepted input carries one signed I sample and one signed Q sample. After every 48 accepted inputs the block presents one filtered I/Q pair. The arithmetic is time-multiplexed. A small bank of multipliers per rail reads a sample delay line at every 48th stage, and the coefficients they use rotate by one phase on every accepted input. The products of a full round of phases add up in a wide accumulator. The result matches a full-rate FIR whose output is then thinned to one sample in 48. The filtering always happens before the rate reduction, never after it.

The coefficients are fixed and computed at elaboration, and the same set serves both rails. A small control state machine tracks the phase and has three states. ST_EMPTY is the state after reset, before any sample has arrived. ST_COLLECT covers phases that are still gathering products. ST_FINAL means the next accepted input completes an output. The transitions are:

- ST_EMPTY to ST_COLLECT on the first accepted input.
- ST_COLLECT to ST_FINAL when the phase about to be entered is the last one.
- ST_FINAL to ST_COLLECT on the accepted input that dumps the accumulator.
- Any state stays where it is on a cycle with no accepted input.

The final sum is rounded and saturated, so it can never wrap.

Top module: `polydec_fir`

## Requirements
- R1: Exactly one output pulse is produced for every 48 accepted inputs. The first pulse comes only after the 48th accepted input since reset. Accepted inputs are numbered from 0 after reset, and the pulses belong to inputs 47, 95, 143 and so on.
- R2: `out_valid` is high for exactly one clock. That clock is the cycle right after the rising edge that accepted the completing input.
- R3: The kept output equals y[n] = sum over t = 0..143 of h[t]·x[n−t], taken at each completing index n, with x = 0 before reset. The coefficients are h[t] = 1800·(t+1) for t < 72 and h[t] = 1800·(144−t) for t ≥ 72.
- R4: Rounding is floor((acc + 2^20) / 2^21), which is round-half-up of the full-precision sum scaled by 2^-21.
- R5: Rounded values outside [−131072, 131071] clamp to the nearest limit. A full-scale constant input of either polarity reaches a limit.
- R6: The I and Q rails use the same coefficients and the same timing. Each rail's output depends only on that rail's inputs.
- R7: A cycle with `in_valid` low changes neither the phase, the delay line nor the accumulators. The values on `in_i` and `in_q` during such a cycle have no effect on any later output.
- R8: A synchronous reset sets `out_valid`, `out_i` and `out_q` to zero and clears the sample history. After reset the outputs are as if all earlier inputs were zero.
- R9: `out_i` and `out_q` hold their last values on every cycle without an output pulse.
- R10: The accumulator is zero on the cycle of each output pulse, so no products carry over from one output window to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase input sample, signed |
| in_q | input | 16 | Quadrature input sample, signed |
| out_valid | output | 1 | One-clock pulse marking a new output sample |
| out_i | output | 18 | Filtered in-phase output, signed |
| out_q | output | 18 | Filtered quadrature output, signed |

## Verification
The hardest condition to reach is an exact match with the single-rate reference across phase boundaries when strobes are irregular. The window only lines up if the phase counter and the delay line both ignore idle cycles. That holds even when the idle-cycle data is garbage and a completing input arrives right after a gap. The bench inserts idle cycles in a repeating pattern and drives a fixed nonzero value during them. It then compares every kept output with a behavioural full-rate filter evaluated on the accepted samples only. Saturation of both polarities is reached with constant full-scale inputs held over several whole windows. Leftover history after reset is exposed by running an impulse test straight after the full-scale test.

// File: rtl/polydec_pkg.sv
package polydec_pkg;

    localparam int DECIM     = 48;
    localparam int TAPS      = 144;
    localparam int IN_W      = 16;
    localparam int COEF_W    = 18;
    localparam int OUT_W     = 18;
    localparam int COEF_STEP = 1800;
    localparam int OUT_SHIFT = 21;

    localparam int MULTS    = TAPS / DECIM;
    localparam int PH_W     = $clog2(DECIM);
    localparam int PROD_W   = IN_W + COEF_W;
    localparam int ACC_W    = IN_W + COEF_W + $clog2(TAPS);
    localparam int LINE_LEN = (MULTS - 1) * DECIM;
    localparam int LAST_PH  = DECIM - 1;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_COLLECT,
        ST_FINAL
    } ctrl_state_t;

    localparam logic signed [ACC_W:0] RND_HALF = (ACC_W+1)'(1) << (OUT_SHIFT - 1);
    localparam logic signed [ACC_W:0] SAT_HI   = (ACC_W+1)'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W:0] SAT_LO   = -SAT_HI - (ACC_W+1)'(1);

    // Symmetric triangular low-pass response, peak at the centre taps.
    function automatic logic signed [COEF_W-1:0] coef_at(input int t);
        int v;
        if (t < TAPS / 2) v = COEF_STEP * (t + 1);
        else              v = COEF_STEP * (TAPS - t);
        return COEF_W'(v);
    endfunction

    // Round half up, then clamp into the output range.
    function automatic logic signed [OUT_W-1:0] round_sat(input logic signed [ACC_W-1:0] a);
        logic signed [ACC_W:0] ext;
        logic signed [ACC_W:0] biased;
        logic signed [ACC_W:0] scaled;
        ext    = {a[ACC_W-1], a};
        biased = ext + RND_HALF;
        scaled = biased >>> OUT_SHIFT;
        if (scaled > SAT_HI)      return SAT_HI[OUT_W-1:0];
        else if (scaled < SAT_LO) return SAT_LO[OUT_W-1:0];
        else                      return scaled[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/polydec_ctrl.sv
module polydec_ctrl
    import polydec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic [PH_W-1:0] phase,
    output logic            dump,
    output logic            out_valid
);

    ctrl_state_t     state;
    ctrl_state_t     state_nx;
    logic [PH_W-1:0] phase_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_EMPTY;
            phase <= '0;
        end else begin
            state <= state_nx;
            phase <= phase_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        phase_nx = phase;
        if (in_valid) begin
            unique case (state)
                ST_EMPTY, ST_COLLECT: begin
                    phase_nx = phase + PH_W'(1);
                    state_nx = (phase_nx == PH_W'(LAST_PH)) ? ST_FINAL : ST_COLLECT;
                end
                ST_FINAL: begin
                    phase_nx = '0;
                    state_nx = ST_COLLECT;
                end
                default: begin
                    phase_nx = '0;
                    state_nx = ST_EMPTY;
                end
            endcase
        end
    end

    assign dump = in_valid && (state == ST_FINAL);

    // Output process
    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= dump;
    end

endmodule

// File: rtl/polydec_coef.sv
module polydec_coef
    import polydec_pkg::*;
(
    input  logic [PH_W-1:0]              phase,
    output logic [MULTS-1:0][COEF_W-1:0] coef
);

    // Multiplier m at phase p applies tap index m*DECIM + (DECIM-1-p).
    for (genvar m = 0; m < MULTS; m++) begin : g_bank
        logic [COEF_W-1:0] rom [DECIM];
        for (genvar k = 0; k < DECIM; k++) begin : g_ent
            assign rom[k] = coef_at(m * DECIM + (DECIM - 1 - k));
        end
        assign coef[m] = (int'(phase) < DECIM) ? rom[phase] : '0;
    end

endmodule

// File: rtl/polydec_tapline.sv
module polydec_tapline
    import polydec_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       step,
    input  logic [IN_W-1:0]            din,
    output logic [MULTS-1:0][IN_W-1:0] taps
);

    assign taps[0] = din;

    if (MULTS > 1) begin : g_line
        logic [IN_W-1:0] line [LINE_LEN];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < LINE_LEN; s++) line[s] <= '0;
            end else if (step) begin
                line[0] <= din;
                for (int s = 1; s < LINE_LEN; s++) line[s] <= line[s-1];
            end
        end

        // Only every DECIM-th stage feeds a multiplier; the rest are pipe.
        for (genvar m = 1; m < MULTS; m++) begin : g_tap
            assign taps[m] = line[m*DECIM - 1];
        end
    end

endmodule

// File: rtl/polydec_mac.sv
module polydec_mac
    import polydec_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         step,
    input  logic                         dump,
    input  logic [MULTS-1:0][IN_W-1:0]   taps,
    input  logic [MULTS-1:0][COEF_W-1:0] coef,
    output logic signed [ACC_W-1:0]      acc,
    output logic signed [OUT_W-1:0]      result
);

    logic signed [PROD_W-1:0] prod [MULTS];
    logic signed [ACC_W-1:0]  psum;
    logic signed [ACC_W-1:0]  acc_nx;

    for (genvar m = 0; m < MULTS; m++) begin : g_mul
        assign prod[m] = $signed(taps[m]) * $signed(coef[m]);
    end

    always_comb begin
        psum = '0;
        for (int m = 0; m < MULTS; m++) psum = psum + ACC_W'(prod[m]);
        acc_nx = acc + psum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            result <= '0;
        end else if (step) begin
            if (dump) begin
                acc    <= '0;
                result <= round_sat(acc_nx);
            end else begin
                acc    <= acc_nx;
            end
        end
    end

endmodule

// File: rtl/polydec_fir.sv
module polydec_fir
    import polydec_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_i,
    input  logic signed [IN_W-1:0]  in_q,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q
);

    localparam int RAILS = 2;

    logic [PH_W-1:0]              phase;
    logic                         dump;
    logic [MULTS-1:0][COEF_W-1:0] coef;

    logic [IN_W-1:0]         rail_in  [RAILS];
    logic signed [ACC_W-1:0] rail_acc [RAILS];
    logic signed [OUT_W-1:0] rail_out [RAILS];

    assign rail_in[0] = in_i;
    assign rail_in[1] = in_q;

    polydec_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .phase     (phase),
        .dump      (dump),
        .out_valid (out_valid)
    );

    polydec_coef u_coef (
        .phase (phase),
        .coef  (coef)
    );

    for (genvar r = 0; r < RAILS; r++) begin : g_rail
        logic [MULTS-1:0][IN_W-1:0] taps;

        polydec_tapline u_line (
            .clk  (clk),
            .rst  (rst),
            .step (in_valid),
            .din  (rail_in[r]),
            .taps (taps)
        );

        polydec_mac u_mac (
            .clk    (clk),
            .rst    (rst),
            .step   (in_valid),
            .dump   (dump),
            .taps   (taps),
            .coef   (coef),
            .acc    (rail_acc[r]),
            .result (rail_out[r])
        );
    end

    assign out_i = rail_out[0];
    assign out_q = rail_out[1];

endmodule

// File: rtl/polydec_fir_chk.sv
module polydec_fir_chk
    import polydec_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic [PH_W-1:0]         phase,
    input logic signed [ACC_W-1:0] acc_i,
    input logic signed [ACC_W-1:0] acc_q,
    input logic signed [OUT_W-1:0] out_i,
    input logic signed [OUT_W-1:0] out_q
);

    AST_ONE_CLOCK_PULSE: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid); // R2
    AST_PULSE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst) (in_valid && phase == PH_W'(LAST_PH)) |=> out_valid); // R1
    AST_PULSE_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(in_valid)); // R1
    AST_IDLE_PHASE_HELD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(phase)); // R7
    AST_IDLE_ACC_HELD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(acc_i) && $stable(acc_q))); // R7
    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst) out_valid |-> (acc_i == '0 && acc_q == '0)); // R10
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst) !out_valid |-> ($stable(out_i) && $stable(out_q))); // R9

endmodule

bind polydec_fir polydec_fir_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .phase     (phase),
    .acc_i     (rail_acc[0]),
    .acc_q     (rail_acc[1]),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/polydec_fir_bench.sv
module polydec_fir_bench;

    localparam int CLK_NS = 10;
    localparam int D      = 48;
    localparam int NT     = 144;
    localparam int MAXN   = 512;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic               out_valid;
    logic signed [17:0] out_i;
    logic signed [17:0] out_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    longint xi [MAXN];
    longint xq [MAXN];
    longint last_i, last_q;

    always #(CLK_NS/2) clk = ~clk;

    polydec_fir u_polydec_fir (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_i      (in_i),
        .in_q      (in_q),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint h(input int t);
        return (t < NT/2) ? 1800 * (t + 1) : 1800 * (NT - t);
    endfunction

    // R3/R4/R5 reference: full-rate filter at index n, rounded and clamped.
    function automatic longint ref_out(input bit q, input int n);
        longint s = 0;
        longint r;
        for (int t = 0; t < NT; t++)
            if (n - t >= 0) s += h(t) * (q ? xq[n-t] : xi[n-t]);
        r = (s + (64'sd1 <<< 20)) >>> 21;
        if (r > 131071)  r = 131071;
        if (r < -131072) r = -131072;
        return r;
    endfunction

    function automatic longint gen(input int kind, input bit q, input int k);
        real w;
        unique case (kind)
            0: return (!q && k == 5) ? 1000 : ((q && k == 60) ? -1000 : 0);
            1: begin
                w = 2.0 * 3.14159265358979 * 0.0123 * k;
                return q ? longint'($rtoi(8000.0 * $sin(w))) : longint'($rtoi(8000.0 * $cos(w)));
            end
            2: return q ? -32768 : 32767;
            default: return q ? (((k * 7717 + 999) % 65536) - 32768)
                              : (((k * 40503 + 12345) % 65536) - 32768);
        endcase
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        in_i = '0;
        in_q = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        last_i = 0;
        last_q = 0;
    endtask

    // Feeds n accepted samples, optionally with idle cycles carrying junk,
    // and checks every cycle's outputs against the reference.
    task automatic run_stream(input int kind, input int n, input bit gaps, input string tag);
        int idx = 0;
        int cyc = 0;
        bit expect_pulse = 0;
        longint ei = 0, eq = 0;
        do_reset();
        while (idx < n || expect_pulse) begin
            if (cyc > 0) @(negedge clk);
            if (expect_pulse) begin
                check(out_valid === 1'b1, {tag, " R2 pulse after completing input"}, out_valid, 1);
                check(longint'(out_i) == ei, {tag, " R3 I output"}, out_i, ei);
                check(longint'(out_q) == eq, {tag, " R6 Q output"}, out_q, eq);
                last_i = out_i;
                last_q = out_q;
            end else if (cyc > 0) begin
                check(out_valid === 1'b0, {tag, " R1 no pulse mid-window"}, out_valid, 0);
                check(longint'(out_i) == last_i && longint'(out_q) == last_q,
                      {tag, " R9 output held"}, out_i, last_i);
            end
            expect_pulse = 0;
            if (idx < n && !(gaps && (cyc % 3 == 1 || cyc % 7 == 4))) begin
                xi[idx] = gen(kind, 0, idx);
                xq[idx] = gen(kind, 1, idx);
                in_valid = 1'b1;
                in_i = 16'(xi[idx]);
                in_q = 16'(xq[idx]);
                idx++;
                if (idx % D == 0) begin
                    expect_pulse = 1;
                    ei = ref_out(0, idx - 1);
                    eq = ref_out(1, idx - 1);
                end
            end else begin
                in_valid = 1'b0;
                in_i = 16'sh7A5A;   // R7: junk on idle cycles must not matter
                in_q = -16'sh3C3C;
            end
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b0, {tag, " R2 pulse lasts one clock"}, out_valid, 0);
    endtask

    task automatic test_reset();
        do_reset();
        check(out_valid === 1'b0, "R8 out_valid after reset", out_valid, 0);
        check(out_i == 0 && out_q == 0, "R8 outputs zero after reset", out_i, 0);
    endtask

    task automatic test_fullscale();
        run_stream(2, D * 4, 0, "R5 full-scale");
        check(longint'(out_i) == 131071, "R5 positive clamp", out_i, 131071);
        check(longint'(out_q) == -131072, "R5 negative clamp", out_q, -131072);
    endtask

    task automatic test_impulse();
        run_stream(0, D * 4, 0, "R8 impulse after full-scale");
    endtask

    task automatic test_tone_gaps();
        run_stream(1, D * 6, 1, "R7 tone with idle gaps");
    endtask

    task automatic test_dense();
        run_stream(3, D * 6, 0, "R4 R10 dense pseudo-random");
    endtask

    initial begin
        test_reset();
        test_fullscale();
        test_impulse();
        test_tone_gaps();
        test_dense();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule